// File: doc/BRIEF.md
# UART Mode Register with Power and Direction Gating

This block pairs an 8-bit control register with a small 8N1 serial transmitter and receiver. The register holds a master power bit, separate transmit and receive enables, and configuration fields for parity, character length, stop length and receive-interrupt mode. The three gating bits decide whether the serial engine runs at all, and which half of it runs. The configuration fields are stored and read back only. Their meaning belongs to a wider core.

Clearing the power bit resets the whole engine asynchronously. The transmit line is forced idle-high, the receive input is treated as idle-high, the 16x oversampling tick is stopped, and the receive buffer, framing-error flag and transmit-busy status are all cleared. Clearing only one direction enable resets that half synchronously and leaves the other half alone. Software may rewrite the register with either a full byte or a single bit. A rewrite with an unchanged value leaves any transfer in progress intact.

Top module: `serial_mode_gate`

## Requirements
- R1: After reset the register reads 0x01. Field layout: bit 7 power, bit 6 transmit enable, bit 5 receive enable, bits 4:3 parity select, bit 2 length, bit 1 stop length, bit 0 receive-interrupt mode.
- R2: A write with `reg_bit_op`=0 loads all 8 bits from `reg_wdata`. A write with `reg_bit_op`=1 loads `reg_wdata[0]` into bit `reg_bit_idx` and leaves the other seven bits unchanged.
- R3: While bit 7 is 0, `txd` is 1, `tx_busy` is 0, `rx_buf` is 0 and `rx_err` is 0. These take effect in the same cycle in which the cleared bit appears in the register.
- R4: While bit 7 is 0, activity on `rxd` produces no received byte and no `rx_valid` pulse.
- R5: `tx_accept` is 1 exactly when `tx_start` is 1, bits 7 and 6 are both 1, and no frame is in progress. A frame starts only on an accepted request.
- R6: A transmitted frame consists of one low start bit, the data bits LSB first and one high stop bit. Each bit lasts 16 `baud_tick` pulses.
- R7: If bit 6 is cleared during a frame, the frame is aborted. `tx_busy` falls and `txd` returns high one clock after the write takes effect.
- R8: Rewriting the register with its current value during a frame leaves that frame unchanged.
- R9: The receiver samples each bit near its middle. At the stop bit it stores the byte in `rx_buf` and pulses `rx_valid` for one clock. It sets `rx_err` to 1 if the stop bit is low and to 0 if it is high.
- R10: Clearing bit 5 resets only the receive state machine. `rx_buf`, `rx_err` and any transmission in progress keep their values.
- R11: The receiver searches for a start bit only while bits 7 and 5 are both 1. A frame that arrives while bit 5 is 0 is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_bit_op | input | 1 | 1 = single-bit write, 0 = full-byte write |
| reg_bit_idx | input | 3 | Bit targeted by a single-bit write |
| reg_wdata | input | 8 | Write data (bit 0 only for a single-bit write) |
| reg_rdata | output | 8 | Current register value |
| baud_tick | input | 1 | 16x oversampling tick |
| tx_start | input | 1 | Transmit request |
| tx_data | input | DATA_BITS | Byte to transmit |
| tx_accept | output | 1 | Request taken this cycle |
| tx_busy | output | 1 | Frame in progress |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_buf | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | One-clock pulse when a byte is stored |
| rx_err | output | 1 | Framing error of the last frame |

## Verification
The bench builds the block with its default parameters: 8 data bits, 16x oversampling and a two-stage input synchronizer. It drives `baud_tick` once every four clocks, so a full frame takes 640 cycles. This short frame lets normal frames, aborted frames, frames with a bad stop bit and frames arriving while the receiver or power is off all be covered in one short run. A behavioural model of the register and of the transmit line is checked against the outputs on every clock. Received bytes, the error flag and the `rx_valid` pulse count are checked after each frame.

// File: rtl/smg_pkg.sv
package smg_pkg;
   localparam int unsigned MODE_W    = 8;
   localparam int unsigned F_PWR     = 7;
   localparam int unsigned F_TXEN    = 6;
   localparam int unsigned F_RXEN    = 5;
   localparam int unsigned F_PAR_HI  = 4;
   localparam int unsigned F_PAR_LO  = 3;
   localparam int unsigned F_LEN     = 2;
   localparam int unsigned F_STOP    = 1;
   localparam int unsigned F_RXIRQ   = 0;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_t;
endpackage

// File: rtl/smg_mode_reg.sv
module smg_mode_reg #(
   parameter int unsigned        W         = 8,
   parameter logic [W-1:0]       RESET_VAL = 8'h01
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic                  bit_op,
   input  logic [$clog2(W)-1:0]  bit_idx,
   input  logic [W-1:0]          wdata,
   output logic [W-1:0]          q
);
   logic [W-1:0] nxt;
   logic [W-1:0] bit_mask;

   assign bit_mask = W'(1) << bit_idx;

   always_comb begin
      nxt = q;
      if (we) begin
         if (bit_op) nxt = (q & ~bit_mask) | (wdata[0] ? bit_mask : '0);
         else        nxt = wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RESET_VAL;
      else        q <= nxt;
   end

   // R2: a single-bit write touches no other bit
   a_r2_bit_write_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (we && bit_op) |=> (((q ^ $past(q)) & ~$past(bit_mask)) == '0));
endmodule

// File: rtl/smg_sync.sv
module smg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain <= '1;
            else if (STAGES == 1) chain <= d;
            else chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/smg_tx.sv
module smg_tx #(
   parameter int unsigned DATA_BITS = 8,
   parameter int unsigned OVS       = 16
) (
   input  logic                 clk,
   input  logic                 arst_n,
   input  logic                 enable,
   input  logic                 tick,
   input  logic                 start,
   input  logic [DATA_BITS-1:0] data,
   output logic                 accept,
   output logic                 busy,
   output logic                 line
);
   localparam int unsigned FRAME = DATA_BITS + 2;
   localparam int unsigned BW    = $clog2(FRAME);
   localparam int unsigned CW    = $clog2(OVS);

   logic [FRAME-1:0] shreg;
   logic [BW-1:0]    nbit;
   logic [CW-1:0]    cnt;

   assign accept = start && enable && !busy;
   assign line   = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         busy  <= 1'b0;
         shreg <= '1;
         nbit  <= '0;
         cnt   <= '0;
      end else if (!enable) begin
         busy  <= 1'b0;
         shreg <= '1;
         nbit  <= '0;
         cnt   <= '0;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            shreg <= {1'b1, data, 1'b0};
            nbit  <= '0;
            cnt   <= '0;
         end
      end else if (tick) begin
         if (cnt == CW'(OVS - 1)) begin
            cnt   <= '0;
            shreg <= {1'b1, shreg[FRAME-1:1]};
            if (nbit == BW'(FRAME - 1)) busy <= 1'b0;
            else                        nbit <= nbit + 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R5: an accepted request starts a frame
   a_r5_accept_starts: assert property (@(posedge clk) disable iff (!arst_n)
      accept |=> busy);
   // R7: a cleared enable ends any frame on the next clock
   a_r7_abort_on_disable: assert property (@(posedge clk) disable iff (!arst_n)
      !enable |=> !busy);
   // R6: every frame opens with a low start bit
   a_r6_start_bit_low: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(busy) |-> !line);
endmodule

// File: rtl/smg_rx.sv
module smg_rx
   import smg_pkg::*;
#(
   parameter int unsigned DATA_BITS = 8,
   parameter int unsigned OVS       = 16
) (
   input  logic                 clk,
   input  logic                 arst_n,
   input  logic                 enable,
   input  logic                 tick,
   input  logic                 rxs,
   output logic [DATA_BITS-1:0] data,
   output logic                 valid,
   output logic                 err
);
   localparam int unsigned CW   = $clog2(OVS);
   localparam int unsigned BW   = $clog2(DATA_BITS);
   localparam int unsigned HALF = OVS / 2;

   rx_state_t            st;
   logic [CW-1:0]        cnt;
   logic [BW-1:0]        nbit;
   logic [DATA_BITS-1:0] sh;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st    <= RX_IDLE;
         cnt   <= '0;
         nbit  <= '0;
         sh    <= '0;
         data  <= '0;
         valid <= 1'b0;
         err   <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (!enable) begin
            st   <= RX_IDLE;
            cnt  <= '0;
            nbit <= '0;
         end else if (tick) begin
            unique case (st)
               RX_IDLE: begin
                  if (!rxs) begin
                     st  <= RX_START;
                     cnt <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == CW'(HALF - 1)) begin
                     cnt  <= '0;
                     nbit <= '0;
                     st   <= rxs ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == CW'(OVS - 1)) begin
                     cnt <= '0;
                     sh  <= {rxs, sh[DATA_BITS-1:1]};
                     if (nbit == BW'(DATA_BITS - 1)) st <= RX_STOP;
                     else                            nbit <= nbit + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == CW'(OVS - 1)) begin
                     cnt   <= '0;
                     st    <= RX_IDLE;
                     data  <= sh;
                     err   <= !rxs;
                     valid <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   // R9: a stored byte is flagged for a single clock only
   a_r9_valid_single_pulse: assert property (@(posedge clk) disable iff (!arst_n)
      valid |=> !valid);
   // R11: no byte is reported while reception is disabled
   a_r11_no_capture_disabled: assert property (@(posedge clk) disable iff (!arst_n)
      !enable |=> !valid);
   // R10: the buffer changes only when a byte is reported
   a_r10_buffer_stable: assert property (@(posedge clk) disable iff (!arst_n)
      !valid |-> $stable(data) || $past(!arst_n));
endmodule

// File: rtl/serial_mode_gate.sv
module serial_mode_gate
   import smg_pkg::*;
#(
   parameter int unsigned         DATA_BITS   = 8,
   parameter int unsigned         OVS         = 16,
   parameter int unsigned         SYNC_STAGES = 2,
   parameter logic [MODE_W-1:0]   MODE_RESET  = 8'h01
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic                 reg_bit_op,
   input  logic [2:0]           reg_bit_idx,
   input  logic [7:0]           reg_wdata,
   output logic [7:0]           reg_rdata,
   input  logic                 baud_tick,
   input  logic                 tx_start,
   input  logic [DATA_BITS-1:0] tx_data,
   output logic                 tx_accept,
   output logic                 tx_busy,
   output logic                 txd,
   input  logic                 rxd,
   output logic [DATA_BITS-1:0] rx_buf,
   output logic                 rx_valid,
   output logic                 rx_err
);
   generate
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_bits
         $error("DATA_BITS must lie between 5 and 9");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
   endgenerate

   logic [MODE_W-1:0] mode;
   logic              pwr;
   logic              eng_rst_n;
   logic              tick_g;
   logic              tx_go;
   logic              rx_go;
   logic              rxd_g;
   logic              rxs;
   logic              tx_line;

   smg_mode_reg #(.W(MODE_W), .RESET_VAL(MODE_RESET)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .bit_op  (reg_bit_op),
      .bit_idx (reg_bit_idx),
      .wdata   (reg_wdata),
      .q       (mode)
   );

   assign reg_rdata = mode;
   assign pwr       = mode[F_PWR];
   assign eng_rst_n = rst_n & pwr;
   assign tick_g    = baud_tick & pwr;
   assign tx_go     = pwr & mode[F_TXEN];
   assign rx_go     = pwr & mode[F_RXEN];
   assign rxd_g     = rxd | ~pwr;
   assign txd       = pwr ? tx_line : 1'b1;

   smg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (eng_rst_n),
      .d      (rxd_g),
      .q      (rxs)
   );

   smg_tx #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_tx (
      .clk    (clk),
      .arst_n (eng_rst_n),
      .enable (tx_go),
      .tick   (tick_g),
      .start  (tx_start),
      .data   (tx_data),
      .accept (tx_accept),
      .busy   (tx_busy),
      .line   (tx_line)
   );

   smg_rx #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_rx (
      .clk    (clk),
      .arst_n (eng_rst_n),
      .enable (rx_go),
      .tick   (tick_g),
      .rxs    (rxs),
      .data   (rx_buf),
      .valid  (rx_valid),
      .err    (rx_err)
   );

   // R3: with power off the line idles and all status reads clear
   a_r3_power_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[F_PWR] |-> (txd && !tx_busy && !rx_err && rx_buf == '0));
   // R5: no request is taken while transmit is gated off
   a_r5_no_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rdata[F_PWR] && reg_rdata[F_TXEN]) |-> !tx_accept);
endmodule

// File: tb/serial_mode_gate_bench.sv
module serial_mode_gate_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic       reg_bit_op = 1'b0;
   logic [2:0] reg_bit_idx = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       baud_tick = 1'b0;
   logic       tx_start = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_accept, tx_busy, txd;
   logic       rxd = 1'b1;
   logic [7:0] rx_buf;
   logic       rx_valid, rx_err;

   int vectors = 0;
   int miss = 0;
   int pulses = 0;
   int tdiv = 0;
   bit done = 0;
   bit running = 0;

   // behavioural reference state
   logic [7:0] m_mode;
   logic [9:0] m_frame;
   bit         m_busy;
   int         m_bit, m_tk;

   serial_mode_gate u_serial_mode_gate (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_bit_op(reg_bit_op),
      .reg_bit_idx(reg_bit_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .baud_tick(baud_tick), .tx_start(tx_start), .tx_data(tx_data),
      .tx_accept(tx_accept), .tx_busy(tx_busy), .txd(txd), .rxd(rxd),
      .rx_buf(rx_buf), .rx_valid(rx_valid), .rx_err(rx_err)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miss++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model, advanced on every clock
   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 8'h01; m_busy = 0; m_bit = 0; m_tk = 0; m_frame = '1;
      end else begin
         if (m_mode[7] && m_mode[6]) begin
            if (!m_busy) begin
               if (tx_start) begin
                  m_frame = {1'b1, tx_data, 1'b0}; m_busy = 1; m_bit = 0; m_tk = 0;
               end
            end else if (baud_tick) begin
               if (m_tk == 15) begin
                  m_tk = 0;
                  if (m_bit == 9) m_busy = 0; else m_bit++;
               end else m_tk++;
            end
         end else m_busy = 0;
         if (reg_we) begin
            if (reg_bit_op) m_mode[reg_bit_idx] = reg_wdata[0];
            else            m_mode = reg_wdata;
         end
         if (!m_mode[7]) m_busy = 0;
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (running) begin
         logic exp_txd;
         exp_txd = !m_mode[7] ? 1'b1 : (m_busy ? m_frame[m_bit] : 1'b1);
         chk(reg_rdata == m_mode, "R2 register readback", reg_rdata, m_mode);
         chk(txd == exp_txd, "R6 txd line", txd, exp_txd);
         chk(tx_busy == m_busy, "R7 tx_busy", tx_busy, m_busy);
         if (rx_valid) pulses++;
      end
   end

   // 16x tick every fourth clock
   initial begin
      forever begin
         @(negedge clk);
         tdiv++;
         baud_tick = (tdiv % 4 == 0);
      end
   end

   task automatic wr_byte(input logic [7:0] v);
      @(negedge clk); reg_we = 1; reg_bit_op = 0; reg_wdata = v;
      @(negedge clk); reg_we = 0;
   endtask

   task automatic wr_bit(input int idx, input bit v);
      @(negedge clk); reg_we = 1; reg_bit_op = 1; reg_bit_idx = 3'(idx); reg_wdata = {7'd0, v};
      @(negedge clk); reg_we = 0; reg_bit_op = 0;
   endtask

   task automatic send_tx(input logic [7:0] b, input bit exp_acc, input string tag);
      @(negedge clk); tx_start = 1; tx_data = b;
      #1 chk(tx_accept == exp_acc, tag, tx_accept, exp_acc);
      @(negedge clk); tx_start = 0;
   endtask

   task automatic send_rx(input logic [7:0] b, input bit stop);
      logic [9:0] bits;
      bits = {stop, b, 1'b0};
      for (int i = 0; i < 10; i++) begin
         rxd = bits[i];
         repeat (64) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (64) @(negedge clk);
   endtask

   initial begin
      int p0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      running = 1;
      @(negedge clk);
      // R1 reset value and idle outputs
      chk(reg_rdata == 8'h01, "R1 reset value", reg_rdata, 8'h01);
      chk(txd == 1'b1, "R3 txd idle after reset", txd, 1);
      chk(rx_buf == 8'h00 && !rx_err, "R3 rx status after reset", {rx_err, rx_buf}, 0);

      // R5: transmit enable alone, power off: not accepted
      wr_byte(8'h41);
      send_tx(8'h5A, 1'b0, "R5 accept with power off");
      repeat (20) @(negedge clk);
      chk(tx_busy == 1'b0, "R5 no frame with power off", tx_busy, 0);

      // R2 byte and single-bit writes
      wr_byte(8'hE0);
      chk(reg_rdata == 8'hE0, "R2 byte write", reg_rdata, 8'hE0);
      wr_bit(1, 1'b1);
      chk(reg_rdata == 8'hE2, "R2 bit set", reg_rdata, 8'hE2);
      wr_bit(1, 1'b0);
      wr_bit(4, 1'b1);
      chk(reg_rdata == 8'hF0, "R2 bit set high field", reg_rdata, 8'hF0);
      wr_byte(8'hE0);

      // R6 full frame, R8 same-value rewrite mid-frame
      send_tx(8'hA5, 1'b1, "R5 accept when enabled");
      send_tx(8'h00, 1'b0, "R5 accept while busy");
      repeat (200) @(negedge clk);
      wr_byte(8'hE0);
      wr_bit(6, 1'b1);
      chk(tx_busy == 1'b1, "R8 frame survives rewrite", tx_busy, 1);
      repeat (500) @(negedge clk);
      chk(tx_busy == 1'b0, "R6 frame complete", tx_busy, 0);

      // R7 abort mid-frame
      send_tx(8'h3C, 1'b1, "R5 accept second frame");
      repeat (100) @(negedge clk);
      wr_byte(8'hA0);
      chk(tx_busy == 1'b1, "R7 busy until next clock", tx_busy, 1);
      @(negedge clk);
      chk(tx_busy == 1'b0 && txd == 1'b1, "R7 abort returns line high", {tx_busy, txd}, 2'b01);
      wr_byte(8'hE0);

      // R9 reception good and bad stop
      p0 = pulses;
      send_rx(8'h3C, 1'b1);
      chk(rx_buf == 8'h3C && !rx_err, "R9 good frame", {rx_err, rx_buf}, 9'h03C);
      chk(pulses == p0 + 1, "R9 one valid pulse", pulses, p0 + 1);
      send_rx(8'h81, 1'b0);
      chk(rx_buf == 8'h81 && rx_err, "R9 framing error", {rx_err, rx_buf}, 9'h181);
      send_rx(8'h55, 1'b1);
      chk(rx_buf == 8'h55 && !rx_err, "R9 error cleared by good frame", {rx_err, rx_buf}, 9'h055);

      // R10 receive disable mid-frame while transmitting
      p0 = pulses;
      fork
         send_tx(8'hC3, 1'b1, "R10 tx accepted");
         begin
            rxd = 1'b0; repeat (64) @(negedge clk);
            rxd = 1'b1; repeat (64) @(negedge clk);
            rxd = 1'b0; repeat (64) @(negedge clk);
            rxd = 1'b1;
         end
         begin
            repeat (150) @(negedge clk);
            wr_bit(5, 1'b0);
         end
      join
      repeat (600) @(negedge clk);
      chk(rx_buf == 8'h55 && !rx_err, "R10 buffer kept", {rx_err, rx_buf}, 9'h055);
      chk(pulses == p0, "R10 no pulse", pulses, p0);

      // R11 frame while receive disabled
      send_rx(8'h33, 1'b1);
      chk(rx_buf == 8'h55 && pulses == p0, "R11 not captured", rx_buf, 8'h55);
      wr_byte(8'hE0);

      // R3 power off mid-transfer clears everything
      send_rx(8'h81, 1'b0);
      chk(rx_err == 1'b1, "R9 error set before power off", rx_err, 1);
      send_tx(8'h0F, 1'b1, "R3 tx before power off");
      repeat (100) @(negedge clk);
      wr_bit(7, 1'b0);
      chk(txd && !tx_busy && rx_buf == 8'h00 && !rx_err, "R3 power off clears",
          {txd, tx_busy, rx_err, rx_buf}, 11'h400);
      chk(reg_rdata == 8'h60, "R3 other bits kept", reg_rdata, 8'h60);

      // R4 rxd ignored while power off
      p0 = pulses;
      send_rx(8'h96, 1'b1);
      chk(rx_buf == 8'h00 && pulses == p0, "R4 rx ignored power off", rx_buf, 0);

      // recovery after power returns
      wr_bit(7, 1'b1);
      repeat (10) @(negedge clk);
      send_rx(8'h5A, 1'b1);
      chk(rx_buf == 8'h5A && !rx_err, "R11 capture after power on", {rx_err, rx_buf}, 9'h05A);

      running = 0;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miss++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
         $finish;
      end
   end
endmodule